// File: doc/BRIEF.md
# Banked Pin Function Register Bank

This block holds the configuration state for a row of multiplexed pins. Each pin can serve as an analog converter input, a digital input, or a digital output. Software reaches the state through a small register port with a 4-bit address and 8-bit data. The address space is split into four groups, one for each kind of field. Each group is divided into banks of eight pins.

The block samples the pad inputs through a synchroniser so they can be read back. It drives the pad output-enable and output-level lines. It also exports a per-pin flag that is set whenever a pin is assigned to a digital function; the converter side uses this flag to mark a conversion result taken from a pin that is not analog. A pin with no digital enable set stays analog. That is also the state after reset.

Top module: `pinmux_regbank`

## Requirements
- R1: Address bits [3:2] select the field group: 0 is sampled input level (read-only), 1 is input enable, 2 is output enable, 3 is output level. Read data always shows the addressed register.
- R2: Within a group, address bits [1:0] = 3 hold pins 0-7, 2 hold pins 8-15, 1 hold pins 16-23 and 0 hold pins 24-31. Bit k of a register belongs to pin (8 × bank + k), where bank = 3 − addr[1:0].
- R3: Writes to addresses 0-3 change no state. The output-enable, output-level and digital-flag outputs stay unchanged, and reads of those addresses still show the sampled pad levels.
- R4: A change on a pad input appears in the readable input-level register after exactly two rising clock edges.
- R5: Synchronous reset clears every input-enable, output-enable and output-level bit and the synchroniser. Every pin then reads as analog, with output-enable low.
- R6: A write to addresses 4-15 stores the write data, and a following read of the same address returns it.
- R7: The output-enable line of a pin equals its output-enable bit. The output-level line equals its output-level bit while the output is enabled, and is low otherwise.
- R8: When both enable bits of a pin are set, the pin drives as an output and is flagged as digital.
- R9: The digital flag of a pin is the OR of its two enable bits. A pin with neither bit set reads as analog (flag low).
- R10: A write to one bank leaves the bits of every other bank and every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Pad output enables |
| pad_out | output | 32 | Pad output levels |
| pin_is_gpio | output | 32 | Per-pin digital-function flag |

## Verification
A one-hot walk sets a single output-enable bit per pin. It shows whether the bank order is reversed or mirrored against the address, because only the expected pad line may rise. Writes to the input-level addresses paired with changing pad levels separate a dropped write guard from a stale synchroniser. A two-step pad change read out edge by edge fixes the synchroniser depth at exactly two. Overlapping input and output enables show output priority. A long run of random writes and random pad levels, compared every cycle against a behavioural model, exposes cross-bank or cross-group disturbance.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

   // Field group selected by the two upper address bits.
   typedef enum logic [1:0] {
      GRP_IN_LVL  = 2'd0,
      GRP_IN_EN   = 2'd1,
      GRP_OUT_EN  = 2'd2,
      GRP_OUT_LVL = 2'd3
   } grp_e;

   // Bank index from the low address bits: the top address holds the lowest pins.
   function automatic int bank_from_low(input int low, input int num_banks);
      return num_banks - 1 - low;
   endfunction

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $fatal(1, "pinmux_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pinmux_field.sv
module pinmux_field
   import pinmux_pkg::*;
#(
   parameter int   NUM_PINS  = 32,
   parameter int   BANK_W    = 8,
   parameter int   NUM_BANKS = 4,
   parameter int   LOW_W     = 2,
   parameter grp_e GRP       = GRP_IN_EN
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [1:0]          grp_sel,
   input  logic [LOW_W-1:0]    low_sel,
   input  logic [BANK_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] q
);
   logic grp_hit;
   assign grp_hit = wr && (grp_e'(grp_sel) == GRP);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [LOW_W-1:0] LOW_CODE = LOW_W'(bank_from_low(b, NUM_BANKS));
         always_ff @(posedge clk) begin
            if (!rst_n)
               q[b*BANK_W +: BANK_W] <= '0;
            else if (grp_hit && low_sel == LOW_CODE)
               q[b*BANK_W +: BANK_W] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/pinmux_dir.sv
module pinmux_dir #(
   parameter int NUM_PINS = 32,
   parameter bit GATE_OUT = 1'b1
) (
   input  logic [NUM_PINS-1:0] in_en,
   input  logic [NUM_PINS-1:0] out_en,
   input  logic [NUM_PINS-1:0] out_lvl,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] is_gpio
);
   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         // Output enable wins over input enable.
         assign pad_oe[p]  = out_en[p];
         assign is_gpio[p] = in_en[p] | out_en[p];
         if (GATE_OUT) begin : g_gate
            assign pad_out[p] = out_en[p] & out_lvl[p];
         end else begin : g_raw
            assign pad_out[p] = out_lvl[p];
         end
      end
   endgenerate
endmodule

// File: rtl/pinmux_regbank.sv
module pinmux_regbank
   import pinmux_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int BANK_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_OUT    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [BANK_W-1:0]   reg_wdata,
   output logic [BANK_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pin_is_gpio
);
   localparam int LOW_W     = ADDR_W - 2;
   localparam int NUM_BANKS = 1 << LOW_W;

   generate
      if (ADDR_W < 3) begin : g_chk_addr
         $fatal(1, "ADDR_W too small for four field groups");
      end
      if (NUM_PINS != NUM_BANKS * BANK_W) begin : g_chk_pins
         $fatal(1, "NUM_PINS must equal banks times bank width");
      end
   endgenerate

   logic [1:0]          grp_sel;
   logic [LOW_W-1:0]    low_sel;
   logic [LOW_W-1:0]    bank_idx;
   logic [NUM_PINS-1:0] in_lvl, in_en, out_en, out_lvl;
   logic [NUM_PINS-1:0] rd_vec;

   assign grp_sel  = reg_addr[ADDR_W-1 -: 2];
   assign low_sel  = reg_addr[LOW_W-1:0];
   assign bank_idx = ~low_sel;

   pinmux_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_lvl)
   );

   pinmux_field #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
                  .LOW_W(LOW_W), .GRP(GRP_IN_EN)) u_in_en (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .grp_sel(grp_sel),
      .low_sel(low_sel), .wdata(reg_wdata), .q(in_en)
   );

   pinmux_field #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
                  .LOW_W(LOW_W), .GRP(GRP_OUT_EN)) u_out_en (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .grp_sel(grp_sel),
      .low_sel(low_sel), .wdata(reg_wdata), .q(out_en)
   );

   pinmux_field #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
                  .LOW_W(LOW_W), .GRP(GRP_OUT_LVL)) u_out_lvl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .grp_sel(grp_sel),
      .low_sel(low_sel), .wdata(reg_wdata), .q(out_lvl)
   );

   pinmux_dir #(.NUM_PINS(NUM_PINS), .GATE_OUT(GATE_OUT)) u_dir (
      .in_en(in_en), .out_en(out_en), .out_lvl(out_lvl),
      .pad_oe(pad_oe), .pad_out(pad_out), .is_gpio(pin_is_gpio)
   );

   always_comb begin
      unique case (grp_e'(grp_sel))
         GRP_IN_LVL:  rd_vec = in_lvl;
         GRP_IN_EN:   rd_vec = in_en;
         GRP_OUT_EN:  rd_vec = out_en;
         default:     rd_vec = out_lvl;
      endcase
      reg_rdata = rd_vec[int'(bank_idx)*BANK_W +: BANK_W];
   end
endmodule

// File: rtl/pinmux_regbank_chk.sv
module pinmux_regbank_chk #(
   parameter int NUM_PINS = 32,
   parameter int BANK_W   = 8,
   parameter int ADDR_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_wr,
   input logic [BANK_W-1:0]   reg_wdata,
   input logic [BANK_W-1:0]   reg_rdata,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pin_is_gpio
);
   localparam int LOW_W     = ADDR_W - 2;
   localparam int NUM_BANKS = 1 << LOW_W;

   function automatic logic [BANK_W-1:0] slice_of(input logic [NUM_PINS-1:0] v,
                                                  input logic [ADDR_W-1:0] a);
      int bank;
      bank = NUM_BANKS - 1 - int'(a[LOW_W-1:0]);
      return v[bank*BANK_W +: BANK_W];
   endfunction

   logic [1:0] live_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   // R5: first cycle after reset shows every pin analog and undriven
   assert_reset_analog_R5: assert property (@(posedge clk)
      (rst_n && !$past(rst_n)) |-> (pad_oe == '0 && pin_is_gpio == '0 && pad_out == '0));

   // R3: writes to the input-level group leave pad controls unchanged
   assert_inlvl_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[ADDR_W-1 -: 2] == 2'd0) |=>
         ($stable(pad_oe) && $stable(pad_out) && $stable(pin_is_gpio)));

   // R4: input-level readback lags the pad by two edges
   assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live_cnt >= 2'd2 && reg_addr[ADDR_W-1 -: 2] == 2'd0) |->
         (reg_rdata == slice_of($past(pad_in, 2), reg_addr)));

   // R6: written data reads back at the same address
   assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[ADDR_W-1 -: 2] != 2'd0) |=>
         (reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata)));

   // R7, R2: an output-enable write lands on the pad lines of the addressed bank
   assert_oe_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[ADDR_W-1 -: 2] == 2'd2) |=>
         (slice_of(pad_oe, $past(reg_addr)) == $past(reg_wdata)));

   // R8, R9: a driven pin is always flagged digital; an undriven pin drives low
   always @(negedge clk) begin
      if (rst_n) begin
         assert_drive_is_gpio_R8: assert ((pad_oe & ~pin_is_gpio) == '0);
         assert_idle_low_R7: assert ((pad_out & ~pad_oe) == '0);
      end
   end
endmodule

bind pinmux_regbank pinmux_regbank_chk #(
   .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
   .pad_oe(pad_oe), .pad_out(pad_out), .pin_is_gpio(pin_is_gpio)
);

// File: tb/pinmux_regbank_bench.sv
module pinmux_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe, pad_out, pin_is_gpio;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pinmux_regbank u_pinmux_regbank (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pin_is_gpio(pin_is_gpio)
   );

   // Behavioural reference: one entry per pin, plus a two-deep input history.
   bit m_ie [32];
   bit m_oe [32];
   bit m_ov [32];
   bit m_s1 [32];
   bit m_s2 [32];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 32; p++) begin
            m_ie[p] = 0; m_oe[p] = 0; m_ov[p] = 0; m_s1[p] = 0; m_s2[p] = 0;
         end
      end else begin
         for (int p = 0; p < 32; p++) begin
            m_s2[p] = m_s1[p];
            m_s1[p] = pad_in[p];
         end
         if (reg_wr) begin
            for (int k = 0; k < 8; k++) begin
               int pin;
               pin = (3 - int'(reg_addr[1:0])) * 8 + k;
               case (int'(reg_addr[3:2]))
                  1: m_ie[pin] = reg_wdata[k];
                  2: m_oe[pin] = reg_wdata[k];
                  3: m_ov[pin] = reg_wdata[k];
                  default: ;
               endcase
            end
         end
      end
   end

   function automatic logic [7:0] exp_rd(input logic [3:0] a);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) begin
         int pin;
         pin = (3 - int'(a[1:0])) * 8 + k;
         case (int'(a[3:2]))
            0: r[k] = m_s2[pin];
            1: r[k] = m_ie[pin];
            2: r[k] = m_oe[pin];
            default: r[k] = m_ov[pin];
         endcase
      end
      return r;
   endfunction

   function automatic logic [31:0] exp_vec(input int which);
      logic [31:0] v;
      for (int p = 0; p < 32; p++) begin
         case (which)
            0: v[p] = m_oe[p];
            1: v[p] = m_oe[p] & m_ov[p];
            default: v[p] = m_ie[p] | m_oe[p];
         endcase
      end
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(reg_rdata == exp_rd(reg_addr), "R1 readback", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
         chk(pad_oe == exp_vec(0), "R7 pad_oe", pad_oe, exp_vec(0));
         chk(pad_out == exp_vec(1), "R7 pad_out", pad_out, exp_vec(1));
         chk(pin_is_gpio == exp_vec(2), "R9 is_gpio", pin_is_gpio, exp_vec(2));
      end
   end

   task automatic drive(input logic [3:0] a, input bit w, input logic [7:0] d);
      @(negedge clk);
      #2;
      reg_addr = a; reg_wr = w; reg_wdata = d;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      drive(a, 1'b1, d);
      drive(a, 1'b0, d);
   endtask

   initial begin
      logic [31:0] snap_oe, snap_out, snap_g;
      pad_in = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      // R5: reset state
      chk(pad_oe == '0, "R5 oe", pad_oe, '0);
      chk(pin_is_gpio == '0, "R5 analog", pin_is_gpio, '0);
      chk(pad_out == '0, "R5 out", pad_out, '0);
      #2 rst_n = 1'b1;
      drive(4'd4, 1'b0, 8'h00);
      @(negedge clk);
      chk(reg_rdata == 8'h00, "R5 in_en clear", 32'(reg_rdata), 32'h0);

      // R6, R2, R9: input enable for pins 0-7 lives at address 7
      wr(4'd7, 8'hA5);
      @(negedge clk);
      chk(reg_rdata == 8'hA5, "R6 readback", 32'(reg_rdata), 32'hA5);
      chk(pin_is_gpio == 32'h0000_00A5, "R9 flag", pin_is_gpio, 32'h0000_00A5);

      // R2, R7: address 8 is pins 24-31
      wr(4'd12, 8'hF0);
      wr(4'd8, 8'h3C);
      @(negedge clk);
      chk(pad_oe == 32'h3C00_0000, "R2 bank order", pad_oe, 32'h3C00_0000);
      chk(pad_out == 32'h3000_0000, "R7 gated level", pad_out, 32'h3000_0000);

      // R8: overlap both enables on pins 26,27
      wr(4'd4, 8'h0C);
      @(negedge clk);
      chk(pad_oe[27:26] == 2'b11, "R8 output priority", 32'(pad_oe[27:26]), 32'h3);
      chk(pin_is_gpio[27:26] == 2'b11, "R8 flagged", 32'(pin_is_gpio[27:26]), 32'h3);

      // R10: bank 1 write leaves bank 3 and other groups
      wr(4'd10, 8'hFF);
      drive(4'd8, 1'b0, 8'h00);
      @(negedge clk);
      chk(reg_rdata == 8'h3C, "R10 isolation", 32'(reg_rdata), 32'h3C);
      chk(pad_oe == 32'h3C00_FF00, "R10 oe map", pad_oe, 32'h3C00_FF00);

      // R3: writes to the read-only group
      snap_oe = pad_oe; snap_out = pad_out; snap_g = pin_is_gpio;
      for (int a = 0; a < 4; a++) wr(4'(a), 8'h5A);
      drive(4'd3, 1'b0, 8'h00);
      @(negedge clk);
      chk(pad_oe == snap_oe && pad_out == snap_out && pin_is_gpio == snap_g,
          "R3 no effect", pad_oe, snap_oe);
      chk(reg_rdata == pad_in[7:0], "R3 pad level", 32'(reg_rdata), 32'(pad_in[7:0]));

      // R4: two-edge latency on pins 0-7 (address 3)
      @(negedge clk); #2 pad_in = 32'h1234_5678;
      @(negedge clk);
      chk(reg_rdata == 8'hEF, "R4 one edge old", 32'(reg_rdata), 32'hEF);
      @(negedge clk);
      chk(reg_rdata == 8'h78, "R4 two edges new", 32'(reg_rdata), 32'h78);
      drive(4'd0, 1'b0, 8'h00);
      @(negedge clk);
      chk(reg_rdata == 8'h12, "R2 top bank input", 32'(reg_rdata), 32'h12);

      // R2: one-hot walk of output enable over every pin
      for (int a = 8; a < 12; a++) wr(4'(a), 8'h00);
      for (int p = 0; p < 32; p++) begin
         wr(4'(8 + 3 - p / 8), 8'(1 << (p % 8)));
         @(negedge clk);
         chk(pad_oe == (32'h1 << p), $sformatf("R2 walk pin %0d", p), pad_oe, 32'h1 << p);
         wr(4'(8 + 3 - p / 8), 8'h00);
      end

      // Random traffic under model comparison (R1, R7, R9, R10)
      for (int i = 0; i < 400; i++) begin
         drive(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 8'($urandom));
         if (i % 5 == 0) pad_in = $urandom;
      end
      drive(4'd0, 1'b0, 8'h00);
      repeat (3) @(negedge clk);

      // R5: reset mid-run clears all state
      #2 rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(pad_oe == '0 && pin_is_gpio == '0, "R5 re-reset", pin_is_gpio, '0);
      #2 rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule